// File: doc/BRIEF.md
# Power-Mode Supervisor

This block is the mode sequencer of a supply-and-bus interface chip that feeds a microcontroller from an on-chip regulator and carries a LIN transceiver. It tracks six modes: shutdown, reset, normal, standby, sleep and thermal shutdown. From the current mode it drives the regulator enable, the active-low reset request to the host, and the mode code for the LIN transceiver (off, wakeup listening, active). The analog comparators, the regulator and the bus driver are outside the block. They reach it as logic flags: supply-above-falling-threshold, supply-above-rising-threshold, regulator undervoltage, over-temperature and a LIN wakeup event.

The host steers the block through two asynchronous pins, EN and TXD. Each passes through a two-flop synchroniser. Raising EN requests normal mode. When EN falls in normal mode, a selection timer starts and TXD is sampled once it expires: TXD high picks standby, TXD low picks sleep. Every recovery path, whether wakeup, cooling down, power-up or a regulator dip, passes through a timed reset mode. That mode holds the host reset low while the regulator is on. All delays are parameters counted in clock ticks, and every delay counter restarts on each mode entry.

Top module: `pwr_mode_supervisor`

## Requirements
- R1: While `rstN` is low, the block is in shutdown: `modeCode` = 0, `vregOn` = 0, `resetReqN` = 0, `linMode` = 0.
- R2: When `supplyOk` goes low, the mode becomes shutdown at once, without waiting for a clock edge, from any mode.
- R3: Shutdown is left only at a clock edge where `supplyHi` = 1 and `overTemp` = 0, and the next mode is always reset.
- R4: Reset mode lasts exactly RESET_TICKS+1 cycles when `vregUv` is low. While `vregUv` is high it is held, and it ends at the first edge where `vregUv` is low after that time. It moves to normal if the synchronised EN is high and to standby otherwise.
- R5: In normal mode, an EN fall starts the selection. The mode changes SEL_TICKS+4 cycles after the pin changes: 2 cycles of synchronisation, 1 cycle of edge detection and SEL_TICKS+1 cycles of timer. TXD high (as seen through its synchroniser) selects standby and TXD low selects sleep. If EN returns high before the sample, the selection is dropped and the mode stays normal.
- R6: In sleep, a `linWake` pulse moves the mode to reset at the next edge. EN going high moves it to reset 3 cycles after the pin change.
- R7: In standby, EN going high moves the mode to normal 3 cycles after the pin change. A `linWake` pulse leaves standby unchanged.
- R8: In normal or standby, `vregUv` held high across UV_FILT_TICKS consecutive edges moves the mode to reset at the following edge. A pulse one edge shorter has no effect.
- R9: `overTemp` high in reset, normal, standby or sleep moves the mode to thermal shutdown at the next edge. Thermal shutdown is left for reset at the first edge where `overTemp` is low.
- R10: The mode codes are: shutdown 0, reset 1, normal 2, standby 3, sleep 4, thermal 5. The LIN mode codes are: off 0, wakeup 1, active 2. The outputs for each mode as {vregOn, resetReqN, linMode} are: shutdown {0,0,0}, reset {1,0,0}, normal {1,1,2}, standby {1,1,1}, sleep {0,0,1}, thermal {0,0,1}.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rstN | input | 1 | Active-low asynchronous reset of all state |
| supplyOk | input | 1 | Battery above its falling threshold; low forces shutdown asynchronously |
| supplyHi | input | 1 | Battery above its rising threshold |
| vregUv | input | 1 | Regulator output below its undervoltage level |
| overTemp | input | 1 | Junction over-temperature flag |
| linWake | input | 1 | Validated LIN wakeup event, one-cycle pulse, synchronous |
| hostEn | input | 1 | Asynchronous host mode-request pin |
| hostTxd | input | 1 | Asynchronous host transmit pin, sampled for the sleep/standby choice |
| vregOn | output | 1 | Regulator enable |
| resetReqN | output | 1 | Active-low reset request to the host |
| linMode | output | 2 | Transceiver mode: 0 off, 1 wakeup, 2 active |
| modeCode | output | 3 | Current mode code |

## Verification
The bench builds the block with RESET_TICKS = 20, SEL_TICKS = 6 and UV_FILT_TICKS = 5. These short values bring the reset-pulse length, the selection instant and the filter edge within a few dozen cycles, so each can be checked at its exact cycle and one cycle earlier. The same short timers let the random phase cycle through all six modes many times, including async supply loss landing in every mode. In that phase each cycle's outputs are compared with the per-mode output table.

// File: rtl/pms_pkg.sv
package pms_pkg;

  typedef enum logic [2:0] {
    MODE_OFF   = 3'd0,
    MODE_RST   = 3'd1,
    MODE_RUN   = 3'd2,
    MODE_STBY  = 3'd3,
    MODE_SLEEP = 3'd4,
    MODE_HOT   = 3'd5
  } pmsMode_e;

  typedef enum logic [1:0] {
    LIN_OFF    = 2'd0,
    LIN_LISTEN = 2'd1,
    LIN_ACTIVE = 2'd2
  } linMode_e;

  // control -> datapath strobes
  typedef struct packed {
    logic clrCnt;   // a mode change happens at this edge
    logic armSel;   // start the sleep/standby selection timer
    logic uvWatch;  // undervoltage filter enabled in this mode
  } ctrlStrobe_t;

  // datapath -> control status
  typedef struct packed {
    logic rstElapsed;
    logic selFire;
    logic uvTrip;
    logic enFall;
  } dpStatus_t;

endpackage

// File: rtl/pms_sync.sv
module pms_sync #(
  parameter int WIDTH = 2,
  parameter int STAGES = 2,
  parameter logic [WIDTH-1:0] RESET_VAL = '0
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WIDTH-1:0] asyncIn,
  output logic [WIDTH-1:0] syncOut
);

  logic [WIDTH-1:0] stageQ [STAGES];

  genvar s;
  generate
    for (s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk or negedge rstN) begin
          if (!rstN) stageQ[0] <= RESET_VAL;
          else       stageQ[0] <= asyncIn;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rstN) begin
          if (!rstN) stageQ[s] <= RESET_VAL;
          else       stageQ[s] <= stageQ[s-1];
        end
      end
    end
  endgenerate

  assign syncOut = stageQ[STAGES-1];

endmodule

// File: rtl/pms_timers.sv
module pms_timers
  import pms_pkg::*;
#(
  parameter int RESET_TICKS = 5000,
  parameter int SEL_TICKS = 28,
  parameter int UV_FILT_TICKS = 23
) (
  input  logic        clk,
  input  logic        rstN,
  input  ctrlStrobe_t strobe,
  input  logic        enS,
  input  logic        vregUv,
  output dpStatus_t   status
);

  localparam int MW = $clog2(RESET_TICKS + 1) + 1;
  localparam int SW = $clog2(SEL_TICKS + 1) + 1;
  localparam int UW = $clog2(UV_FILT_TICKS + 1) + 1;
  localparam logic [MW-1:0] MODE_MAX = MW'(RESET_TICKS);
  localparam logic [SW-1:0] SEL_MAX = SW'(SEL_TICKS);
  localparam logic [UW-1:0] UV_MAX = UW'(UV_FILT_TICKS);

  logic [MW-1:0] modeCnt;
  logic [SW-1:0] selCnt;
  logic          selActive;
  logic [UW-1:0] uvCnt;
  logic          enPrev;

  // time spent in the current mode, saturating
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                   modeCnt <= '0;
    else if (strobe.clrCnt)      modeCnt <= '0;
    else if (modeCnt != MODE_MAX) modeCnt <= modeCnt + 1'b1;
  end

  // selection timer, dropped when EN comes back high
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      selActive <= 1'b0;
      selCnt    <= '0;
    end else if (strobe.clrCnt || enS) begin
      selActive <= 1'b0;
      selCnt    <= '0;
    end else if (strobe.armSel) begin
      selActive <= 1'b1;
      selCnt    <= '0;
    end else if (selActive && selCnt != SEL_MAX) begin
      selCnt <= selCnt + 1'b1;
    end
  end

  // undervoltage persistence filter
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                                        uvCnt <= '0;
    else if (strobe.clrCnt || !strobe.uvWatch || !vregUv) uvCnt <= '0;
    else if (uvCnt != UV_MAX)                         uvCnt <= uvCnt + 1'b1;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) enPrev <= 1'b0;
    else       enPrev <= enS;
  end

  assign status.rstElapsed = (modeCnt == MODE_MAX);
  assign status.selFire    = selActive && (selCnt == SEL_MAX);
  assign status.uvTrip     = (uvCnt == UV_MAX);
  assign status.enFall     = enPrev && !enS;

endmodule

// File: rtl/pms_ctrl.sv
module pms_ctrl
  import pms_pkg::*;
(
  input  logic        clk,
  input  logic        hardRstN,
  input  logic        supplyHi,
  input  logic        overTemp,
  input  logic        linWake,
  input  logic        vregUv,
  input  logic        enS,
  input  logic        txdS,
  input  dpStatus_t   status,
  output ctrlStrobe_t strobe,
  output pmsMode_e    mode,
  output logic        vregOn,
  output logic        resetReqN,
  output linMode_e    linMode
);

  pmsMode_e nextMode;

  always_comb begin
    nextMode = mode;
    case (mode)
      MODE_OFF: begin
        if (supplyHi && !overTemp) nextMode = MODE_RST;
      end
      MODE_RST: begin
        if (overTemp)                               nextMode = MODE_HOT;
        else if (status.rstElapsed && !vregUv)      nextMode = enS ? MODE_RUN : MODE_STBY;
      end
      MODE_RUN: begin
        if (overTemp)            nextMode = MODE_HOT;
        else if (status.uvTrip)  nextMode = MODE_RST;
        else if (status.selFire) nextMode = txdS ? MODE_STBY : MODE_SLEEP;
      end
      MODE_STBY: begin
        if (overTemp)           nextMode = MODE_HOT;
        else if (status.uvTrip) nextMode = MODE_RST;
        else if (enS)           nextMode = MODE_RUN;
      end
      MODE_SLEEP: begin
        if (overTemp)            nextMode = MODE_HOT;
        else if (linWake || enS) nextMode = MODE_RST;
      end
      MODE_HOT: begin
        if (!overTemp) nextMode = MODE_RST;
      end
      default: nextMode = MODE_OFF;
    endcase
  end

  always_ff @(posedge clk or negedge hardRstN) begin
    if (!hardRstN) mode <= MODE_OFF;
    else           mode <= nextMode;
  end

  always_comb begin
    strobe.clrCnt  = (nextMode != mode);
    strobe.armSel  = (mode == MODE_RUN) && status.enFall && (nextMode == mode);
    strobe.uvWatch = (mode == MODE_RUN) || (mode == MODE_STBY);
  end

  always_comb begin
    vregOn    = 1'b0;
    resetReqN = 1'b0;
    linMode   = LIN_OFF;
    case (mode)
      MODE_RST:   vregOn = 1'b1;
      MODE_RUN: begin
        vregOn = 1'b1; resetReqN = 1'b1; linMode = LIN_ACTIVE;
      end
      MODE_STBY: begin
        vregOn = 1'b1; resetReqN = 1'b1; linMode = LIN_LISTEN;
      end
      MODE_SLEEP: linMode = LIN_LISTEN;
      MODE_HOT:   linMode = LIN_LISTEN;
      default: ;
    endcase
  end

endmodule

// File: rtl/pwr_mode_supervisor.sv
module pwr_mode_supervisor
  import pms_pkg::*;
#(
  parameter int RESET_TICKS = 5000,
  parameter int SEL_TICKS = 28,
  parameter int UV_FILT_TICKS = 23,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       supplyOk,
  input  logic       supplyHi,
  input  logic       vregUv,
  input  logic       overTemp,
  input  logic       linWake,
  input  logic       hostEn,
  input  logic       hostTxd,
  output logic       vregOn,
  output logic       resetReqN,
  output logic [1:0] linMode,
  output logic [2:0] modeCode
);

  logic        hardRstN;
  logic [1:0]  pinSync;
  ctrlStrobe_t strobe;
  dpStatus_t   status;
  pmsMode_e    mode;
  linMode_e    linModeE;

  assign hardRstN = rstN & supplyOk;

  // bit 1 = TXD (idles high), bit 0 = EN (idles low)
  pms_sync #(.WIDTH(2), .STAGES(SYNC_STAGES), .RESET_VAL(2'b10)) sync_i (
    .clk(clk), .rstN(rstN), .asyncIn({hostTxd, hostEn}), .syncOut(pinSync)
  );

  pms_timers #(
    .RESET_TICKS(RESET_TICKS), .SEL_TICKS(SEL_TICKS), .UV_FILT_TICKS(UV_FILT_TICKS)
  ) timers_i (
    .clk(clk), .rstN(rstN), .strobe(strobe), .enS(pinSync[0]),
    .vregUv(vregUv), .status(status)
  );

  pms_ctrl ctrl_i (
    .clk(clk), .hardRstN(hardRstN), .supplyHi(supplyHi), .overTemp(overTemp),
    .linWake(linWake), .vregUv(vregUv), .enS(pinSync[0]), .txdS(pinSync[1]),
    .status(status), .strobe(strobe), .mode(mode), .vregOn(vregOn),
    .resetReqN(resetReqN), .linMode(linModeE)
  );

  assign linMode  = linModeE;
  assign modeCode = mode;

endmodule

// File: rtl/pms_checker.sv
module pms_checker (
  input logic       clk,
  input logic       rstN,
  input logic       supplyOk,
  input logic       overTemp,
  input logic       vregOn,
  input logic       resetReqN,
  input logic [1:0] linMode,
  input logic [2:0] modeCode
);

  assert_supply_loss_R2: assert property (@(posedge clk) disable iff (!rstN)
    !supplyOk |-> modeCode == 3'd0);

  assert_off_exit_R3: assert property (@(posedge clk) disable iff (!rstN)
    ($past(rstN) && $past(modeCode) == 3'd0 && modeCode != 3'd0) |-> modeCode == 3'd1);

  assert_sleep_from_normal_R5: assert property (@(posedge clk) disable iff (!rstN)
    ($past(rstN) && modeCode == 3'd4 && $past(modeCode) != 3'd4) |-> $past(modeCode) == 3'd2);

  assert_hot_entry_R9: assert property (@(posedge clk) disable iff (!rstN)
    ($past(rstN) && $past(supplyOk) && supplyOk && $past(overTemp) &&
     $past(modeCode) >= 3'd1 && $past(modeCode) <= 3'd4) |-> modeCode == 3'd5);

  assert_release_powered_R10: assert property (@(posedge clk) disable iff (!rstN)
    resetReqN |-> (vregOn && (modeCode == 3'd2 || modeCode == 3'd3)));

  assert_lin_code_R10: assert property (@(posedge clk) disable iff (!rstN)
    linMode != 2'd3);

endmodule

bind pwr_mode_supervisor pms_checker chk_i (
  .clk(clk), .rstN(rstN), .supplyOk(supplyOk), .overTemp(overTemp),
  .vregOn(vregOn), .resetReqN(resetReqN), .linMode(linMode), .modeCode(modeCode)
);

// File: tb/pwr_mode_supervisor_tb.sv
module pwr_mode_supervisor_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int RST_T = 20;
  localparam int SEL_T = 6;
  localparam int UV_T = 5;

  logic clk = 1'b0;
  logic rstN, supplyOk, supplyHi, vregUv, overTemp, linWake, hostEn, hostTxd;
  logic vregOn, resetReqN;
  logic [1:0] linMode;
  logic [2:0] modeCode;

  int checks = 0;
  int failures = 0;
  bit finished = 1'b0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  pwr_mode_supervisor #(
    .RESET_TICKS(RST_T), .SEL_TICKS(SEL_T), .UV_FILT_TICKS(UV_T)
  ) dut_i (
    .clk(clk), .rstN(rstN), .supplyOk(supplyOk), .supplyHi(supplyHi),
    .vregUv(vregUv), .overTemp(overTemp), .linWake(linWake), .hostEn(hostEn),
    .hostTxd(hostTxd), .vregOn(vregOn), .resetReqN(resetReqN),
    .linMode(linMode), .modeCode(modeCode)
  );

  // R10 output table: {vregOn, resetReqN, linMode}
  function automatic logic [3:0] expOut(input logic [2:0] m);
    case (m)
      3'd0: return 4'b0000;
      3'd1: return 4'b1000;
      3'd2: return 4'b1110;
      3'd3: return 4'b1101;
      3'd4: return 4'b0001;
      3'd5: return 4'b0001;
      default: return 4'b1111;
    endcase
  endfunction

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic checkMode(input string req, input int expMode);
    checks++;
    if (modeCode != 3'(expMode)) begin
      failures++;
      $display("FAIL %s mode actual=%0d expected=%0d t=%0t", req, modeCode, expMode, $time);
    end
    checks++;
    if ({vregOn, resetReqN, linMode} != expOut(3'(expMode))) begin
      failures++;
      $display("FAIL %s outputs actual=%b expected=%b t=%0t", req,
               {vregOn, resetReqN, linMode}, expOut(3'(expMode)), $time);
    end
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!finished) begin
      failures++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    rstN = 0; supplyOk = 0; supplyHi = 0; vregUv = 0; overTemp = 0;
    linWake = 0; hostEn = 0; hostTxd = 1;
    tick(2);
    checkMode("R1 reset state", 0);
    rstN = 1;
    tick(3);
    checkMode("R3 no supply stays off", 0);

    // R3: rising threshold met but hot
    supplyOk = 1; supplyHi = 1; overTemp = 1;
    tick(3);
    checkMode("R3 hot blocks exit", 0);
    overTemp = 0;
    tick(1);
    checkMode("R3 exit to reset", 1);

    // R4: pulse length, EN low -> standby
    tick(RST_T);
    checkMode("R4 reset still held", 1);
    tick(1);
    checkMode("R4 to standby", 3);

    // R7: wakeup ignored in standby
    linWake = 1; tick(1); linWake = 0;
    tick(2);
    checkMode("R7 wake ignored in standby", 3);
    hostEn = 1;
    tick(2);
    checkMode("R7 standby before sync", 3);
    tick(1);
    checkMode("R7 standby to normal", 2);

    // R5: TXD high -> standby
    tick(2);
    hostTxd = 1; hostEn = 0;
    tick(SEL_T + 3);
    checkMode("R5 still normal before sample", 2);
    tick(1);
    checkMode("R5 txd high selects standby", 3);

    // R5: TXD low -> sleep
    hostEn = 1; tick(3);
    checkMode("R7 back to normal", 2);
    hostTxd = 0; hostEn = 0;
    tick(SEL_T + 3);
    checkMode("R5 normal before sleep", 2);
    tick(1);
    checkMode("R5 txd low selects sleep", 4);
    hostTxd = 1;

    // R6: wakeup from sleep, R4: held by undervoltage
    linWake = 1; tick(1); linWake = 0;
    checkMode("R6 wake to reset", 1);
    vregUv = 1;
    tick(RST_T + 5);
    checkMode("R4 held by undervoltage", 1);
    vregUv = 0;
    tick(1);
    checkMode("R4 released to standby", 3);

    // R6: EN high leaves sleep, R4: EN high -> normal
    hostEn = 1; tick(3);
    hostTxd = 0; hostEn = 0; tick(SEL_T + 4);
    checkMode("R5 sleep again", 4);
    hostTxd = 1; hostEn = 1;
    tick(2);
    checkMode("R6 sleep before sync", 4);
    tick(1);
    checkMode("R6 EN wakes to reset", 1);
    tick(RST_T);
    checkMode("R4 reset held", 1);
    tick(1);
    checkMode("R4 to normal with EN high", 2);

    // R5: abandoned selection
    hostTxd = 0; hostEn = 0;
    tick(3);
    hostEn = 1;
    tick(SEL_T + 6);
    checkMode("R5 abandoned selection", 2);
    hostTxd = 1;

    // R8: undervoltage filter
    vregUv = 1; tick(UV_T - 1); vregUv = 0;
    tick(3);
    checkMode("R8 short dip ignored", 2);
    vregUv = 1; tick(UV_T);
    checkMode("R8 filter not yet done", 2);
    tick(1);
    checkMode("R8 dip forces reset", 1);
    vregUv = 0;
    tick(RST_T + 1);
    checkMode("R4 recovered to normal", 2);

    // R9: thermal
    overTemp = 1; tick(1);
    checkMode("R9 hot entry", 5);
    tick(5);
    checkMode("R9 hot held", 5);
    overTemp = 0; tick(1);
    checkMode("R9 cool to reset", 1);
    tick(RST_T + 1);
    checkMode("R4 normal after cool", 2);

    // R2: asynchronous supply loss
    supplyOk = 0; #1;
    checkMode("R2 async shutdown", 0);
    tick(1);
    supplyOk = 1; supplyHi = 0;
    tick(3);
    checkMode("R3 needs rising threshold", 0);
    supplyHi = 1; tick(1);
    checkMode("R3 exit after rise", 1);

    // random phase: per-cycle output table and supply loss
    void'($urandom(32'd20240611));
    for (int i = 0; i < 4000; i++) begin
      if ($urandom_range(0, 199) == 0) supplyOk = ~supplyOk;
      if (!supplyOk && $urandom_range(0, 3) == 0) supplyOk = 1;
      supplyHi = ($urandom_range(0, 9) != 0);
      if ($urandom_range(0, 99) == 0) overTemp = ~overTemp;
      if ($urandom_range(0, 49) == 0) vregUv = ~vregUv;
      linWake = ($urandom_range(0, 39) == 0);
      if ($urandom_range(0, 29) == 0) hostEn = ~hostEn;
      if ($urandom_range(0, 19) == 0) hostTxd = ~hostTxd;
      #1;
      checks++;
      if (modeCode > 3'd5 || {vregOn, resetReqN, linMode} != expOut(modeCode)) begin
        failures++;
        $display("FAIL R10 random table mode=%0d actual=%b expected=%b",
                 modeCode, {vregOn, resetReqN, linMode}, expOut(modeCode));
      end
      if (!supplyOk) begin
        checks++;
        if (modeCode != 3'd0) begin
          failures++;
          $display("FAIL R2 random supply loss actual=%0d expected=0", modeCode);
        end
      end
      tick(1);
    end

    finished = 1'b1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule